// File: doc/BRIEF.md
# Dual-Channel Monitor SPI Register Target

This block is the device side of a serial register port for a two-channel current and voltage monitor. A host selects the target with a low chip select, sends a two-byte header that carries a read/write flag and a 15-bit register address, then clocks any number of 8-bit data bytes. The address steps down by one after every data byte, so one burst walks the register map downward. A fixed set of addresses can be read, a smaller set can be written, and every other access is dropped.

Two 12-bit samples, one voltage and one current, arrive on a parallel stimulus port and wait in shadow registers. They move into the four readable data registers only after the host has read all four data bytes in descending order inside a single burst. This gives the host a coherent pair: the values it reads can never be torn by a sample that lands mid-read. A status register reports readiness a fixed number of cycles after the reset pin is released.

The serial inputs are sampled with the block clock through synchronizer stages, so the serial clock must run several times slower than the block clock.

Top module: `adc_spi_target`

## Requirements
- R1: Serial mode 0, most significant bit first: MOSI is sampled on rising SCLK and MISO changes after falling SCLK. The first header byte's bit 7 is 1 for read and 0 for write; its bits 6..0 followed by the second header byte form the 15-bit address. MISO is low whenever CS_n is high.
- R2: After each data byte of a transfer, read or write, the address decrements by one, so the next byte accesses the next lower register.
- R3: Readable addresses return: 0x0006 chip revision (default 0x02), 0x000C identity low (default 0x51), 0x000D identity high (default 0x04), 0x0002 to 0x0005 read 0x00; any address outside 0x0000-0x0006, 0x000C-0x000D, 0x000F, 0x0100, 0x0103, 0x0200-0x0203 reads 0x00.
- R4: Only 0x0000, 0x0001, 0x000F and 0x0100 accept writes and read back the written value; writes to any other address leave every register unchanged.
- R5: After the reset pin, register 0x0000 reads 0x99, 0x0001 reads 0x00, and 0x000F, 0x0100 and the data registers read 0x00.
- R6: Status at 0x0103 reads 0x00 until READY_CYCLES (default 1000) clock cycles after reset release, then reads 0x01 and stays there.
- R7: Data layout: 0x0200 holds voltage bits 7..0, 0x0201 holds {4'b0, voltage bits 11..8}, 0x0202 holds current bits 7..0, 0x0203 holds {4'b0, current bits 11..8}.
- R8: A pulse on sampleValid captures sampleVolt and sampleCurr into shadow storage; the readable data registers do not change on capture.
- R9: When one transfer reads 0x0203, 0x0202, 0x0201 and 0x0200 as consecutive bytes, the shadow samples are committed after the 0x0200 byte; the bytes of that burst return the values held before the commit.
- R10: No commit happens if CS_n rises before the 0x0200 byte completes, if the four bytes are read in separate transfers, or if the burst starts below 0x0203; pending samples stay in shadow until a later full burst.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock, several times faster than SCLK |
| rstN | input | 1 | Asynchronous active-low reset pin |
| sclk | input | 1 | Serial clock from the host |
| csN | input | 1 | Active-low chip select |
| mosi | input | 1 | Serial data from the host |
| miso | output | 1 | Serial data to the host |
| sampleValid | input | 1 | One-cycle strobe that captures a new sample pair |
| sampleVolt | input | 12 | Voltage sample, unsigned |
| sampleCurr | input | 12 | Current sample, unsigned |

## Verification
The assertions take for granted that SCLK, CS_n and MOSI change slowly enough that each level lasts several block clocks, that CS_n never toggles during an SCLK high phase, and that sampleValid never fires in the cycle a commit lands. The stimulus keeps SCLK half periods at eight block clocks, moves CS_n only while SCLK is low with a half period of margin, and pulses sampleValid only while CS_n is high. Expected read bytes come from a register model that applies the write map and the four-byte commit rule as stated.

// File: rtl/adc_spi_pkg.sv
package adc_spi_pkg;

  localparam int REG_AW = 15;
  localparam int REG_DW = 8;

  localparam logic [REG_AW-1:0] ADR_CFG_A   = 15'h0000;
  localparam logic [REG_AW-1:0] ADR_CFG_B   = 15'h0001;
  localparam logic [REG_AW-1:0] ADR_REV     = 15'h0006;
  localparam logic [REG_AW-1:0] ADR_ID_LO   = 15'h000C;
  localparam logic [REG_AW-1:0] ADR_ID_HI   = 15'h000D;
  localparam logic [REG_AW-1:0] ADR_UPDATE  = 15'h000F;
  localparam logic [REG_AW-1:0] ADR_CTRL    = 15'h0100;
  localparam logic [REG_AW-1:0] ADR_STATUS  = 15'h0103;
  localparam logic [REG_AW-1:0] ADR_VOLT_LO = 15'h0200;
  localparam logic [REG_AW-1:0] ADR_VOLT_HI = 15'h0201;
  localparam logic [REG_AW-1:0] ADR_CURR_LO = 15'h0202;
  localparam logic [REG_AW-1:0] ADR_CURR_HI = 15'h0203;

  // Strobes from the serial control to the register datapath.
  typedef struct packed {
    logic              sel;
    logic              txLoad;
    logic              txShift;
    logic              wrEn;
    logic [REG_DW-1:0] wrData;
    logic              commit;
    logic [REG_AW-1:0] addr;
  } strobe_t;

endpackage

// File: rtl/adc_spi_ctrl.sv
module adc_spi_ctrl
  import adc_spi_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic    clk,
  input  logic    rstN,
  input  logic    sclk,
  input  logic    csN,
  input  logic    mosi,
  output strobe_t strb
);

  localparam int BIT_W = $clog2(REG_DW);
  localparam logic [BIT_W-1:0] LAST_BIT = BIT_W'(REG_DW - 1);

  logic [SYNC_STAGES:0]   sclkPipe;
  logic [SYNC_STAGES-1:0] csnPipe;
  logic [SYNC_STAGES-1:0] mosiPipe;

  logic              sel, sclkRise, sclkFall, mosiQ;
  logic [BIT_W-1:0]  bitCnt;
  logic              inData, hdrSecond, isRead;
  logic [REG_DW-2:0] addrHi;
  logic [REG_DW-1:0] rxShift, rxNext;
  logic [REG_AW-1:0] addr;
  logic [1:0]        seqStep, seqNext;
  logic              seqDone, byteDone;

  assign sel      = !csnPipe[SYNC_STAGES-1];
  assign sclkRise =  sclkPipe[SYNC_STAGES-1] && !sclkPipe[SYNC_STAGES];
  assign sclkFall = !sclkPipe[SYNC_STAGES-1] &&  sclkPipe[SYNC_STAGES];
  assign mosiQ    =  mosiPipe[SYNC_STAGES-1];
  assign rxNext   = {rxShift[REG_DW-2:0], mosiQ};
  assign byteDone = sel && sclkRise && (bitCnt == LAST_BIT);

  // Descending-order tracker for the four data bytes.
  always_comb begin
    seqNext = 2'd0;
    seqDone = 1'b0;
    unique case (addr)
      ADR_CURR_HI: seqNext = 2'd1;
      ADR_CURR_LO: seqNext = (seqStep == 2'd1) ? 2'd2 : 2'd0;
      ADR_VOLT_HI: seqNext = (seqStep == 2'd2) ? 2'd3 : 2'd0;
      ADR_VOLT_LO: seqDone = (seqStep == 2'd3);
      default:     seqNext = 2'd0;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sclkPipe  <= '0;
      csnPipe   <= '1;
      mosiPipe  <= '0;
      bitCnt    <= '0;
      inData    <= 1'b0;
      hdrSecond <= 1'b0;
      isRead    <= 1'b0;
      addrHi    <= '0;
      rxShift   <= '0;
      addr      <= '0;
      seqStep   <= 2'd0;
    end else begin
      sclkPipe <= {sclkPipe[SYNC_STAGES-1:0], sclk};
      csnPipe  <= {csnPipe[SYNC_STAGES-2:0], csN};
      mosiPipe <= {mosiPipe[SYNC_STAGES-2:0], mosi};
      if (!sel) begin
        bitCnt    <= '0;
        inData    <= 1'b0;
        hdrSecond <= 1'b0;
        seqStep   <= 2'd0;
      end else if (sclkRise) begin
        rxShift <= rxNext;
        bitCnt  <= bitCnt + 1'b1;
        if (bitCnt == LAST_BIT) begin
          if (inData) begin
            addr <= addr - 1'b1;
            if (isRead) seqStep <= seqNext;
          end else if (!hdrSecond) begin
            isRead    <= rxNext[REG_DW-1];
            addrHi    <= rxNext[REG_DW-2:0];
            hdrSecond <= 1'b1;
          end else begin
            addr   <= {addrHi, rxNext};
            inData <= 1'b1;
          end
        end
      end
    end
  end

  always_comb begin
    strb.sel     = sel;
    strb.txLoad  = sel && sclkFall && inData && (bitCnt == '0);
    strb.txShift = sel && sclkFall && inData && (bitCnt != '0);
    strb.wrEn    = byteDone && inData && !isRead;
    strb.wrData  = rxNext;
    strb.commit  = byteDone && inData && isRead && seqDone;
    strb.addr    = addr;
  end

  AST_ADDR_STEP: assert property (@(posedge clk) disable iff (!rstN)
    (byteDone && inData) |=> (addr == $past(addr) - 1'b1)); // R2

endmodule

// File: rtl/adc_spi_regs.sv
module adc_spi_regs
  import adc_spi_pkg::*;
#(
  parameter int          SAMPLE_W     = 12,
  parameter int          READY_CYCLES = 1000,
  parameter logic [7:0]  CHIP_REV     = 8'h02,
  parameter logic [7:0]  ID_LO        = 8'h51,
  parameter logic [7:0]  ID_HI        = 8'h04,
  parameter logic [7:0]  CFG_A_RST    = 8'h99,
  parameter logic [7:0]  CFG_B_RST    = 8'h00
) (
  input  logic                clk,
  input  logic                rstN,
  input  strobe_t             strb,
  input  logic                sampleValid,
  input  logic [SAMPLE_W-1:0] sampleVolt,
  input  logic [SAMPLE_W-1:0] sampleCurr,
  output logic                miso
);

  localparam int HI_W  = SAMPLE_W - REG_DW;
  localparam int CNT_W = $clog2(READY_CYCLES + 1);
  localparam logic [CNT_W-1:0] CNT_END = CNT_W'(READY_CYCLES);

  logic [REG_DW-1:0]   cfgA, cfgB, updReg, ctrlReg, rdData, txReg;
  logic [SAMPLE_W-1:0] shVolt, shCurr, dVolt, dCurr;
  logic [CNT_W-1:0]    readyCnt;
  logic                ready;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      readyCnt <= '0;
      ready    <= 1'b0;
    end else if (readyCnt != CNT_END) begin
      readyCnt <= readyCnt + 1'b1;
    end else begin
      ready <= 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cfgA    <= CFG_A_RST;
      cfgB    <= CFG_B_RST;
      updReg  <= '0;
      ctrlReg <= '0;
    end else if (strb.wrEn) begin
      unique case (strb.addr)
        ADR_CFG_A:  cfgA    <= strb.wrData;
        ADR_CFG_B:  cfgB    <= strb.wrData;
        ADR_UPDATE: updReg  <= strb.wrData;
        ADR_CTRL:   ctrlReg <= strb.wrData;
        default:    ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shVolt <= '0;
      shCurr <= '0;
      dVolt  <= '0;
      dCurr  <= '0;
    end else begin
      if (sampleValid) begin
        shVolt <= sampleVolt;
        shCurr <= sampleCurr;
      end
      if (strb.commit) begin
        dVolt <= shVolt;
        dCurr <= shCurr;
      end
    end
  end

  always_comb begin
    rdData = '0;
    unique case (strb.addr)
      ADR_CFG_A:   rdData = cfgA;
      ADR_CFG_B:   rdData = cfgB;
      ADR_REV:     rdData = CHIP_REV;
      ADR_ID_LO:   rdData = ID_LO;
      ADR_ID_HI:   rdData = ID_HI;
      ADR_UPDATE:  rdData = updReg;
      ADR_CTRL:    rdData = ctrlReg;
      ADR_STATUS:  rdData = {{(REG_DW-1){1'b0}}, ready};
      ADR_VOLT_LO: rdData = dVolt[REG_DW-1:0];
      ADR_VOLT_HI: rdData[HI_W-1:0] = dVolt[SAMPLE_W-1:REG_DW];
      ADR_CURR_LO: rdData = dCurr[REG_DW-1:0];
      ADR_CURR_HI: rdData[HI_W-1:0] = dCurr[SAMPLE_W-1:REG_DW];
      default:     rdData = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)             txReg <= '0;
    else if (!strb.sel)    txReg <= '0;
    else if (strb.txLoad)  txReg <= rdData;
    else if (strb.txShift) txReg <= {txReg[REG_DW-2:0], 1'b0};
  end

  assign miso = strb.sel && txReg[REG_DW-1];

  AST_DATA_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !strb.commit |=> ($stable(dVolt) && $stable(dCurr))); // R8
  AST_CFG_WRITE_ONLY: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(cfgA) |-> $past(strb.wrEn && strb.addr == ADR_CFG_A)); // R4
  AST_READY_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    ready |=> ready); // R6
  AST_COMMIT_ADDR: assert property (@(posedge clk) disable iff (!rstN)
    strb.commit |-> (strb.addr == ADR_VOLT_LO && !strb.wrEn)); // R9

endmodule

// File: rtl/adc_spi_target.sv
module adc_spi_target
  import adc_spi_pkg::*;
#(
  parameter int SAMPLE_W     = 12,
  parameter int READY_CYCLES = 1000,
  parameter int SYNC_STAGES  = 2
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                sclk,
  input  logic                csN,
  input  logic                mosi,
  output logic                miso,
  input  logic                sampleValid,
  input  logic [SAMPLE_W-1:0] sampleVolt,
  input  logic [SAMPLE_W-1:0] sampleCurr
);

  strobe_t strb;

  adc_spi_ctrl #(.SYNC_STAGES(SYNC_STAGES)) u_ctrl (
    .clk  (clk),
    .rstN (rstN),
    .sclk (sclk),
    .csN  (csN),
    .mosi (mosi),
    .strb (strb)
  );

  adc_spi_regs #(.SAMPLE_W(SAMPLE_W), .READY_CYCLES(READY_CYCLES)) u_regs (
    .clk         (clk),
    .rstN        (rstN),
    .strb        (strb),
    .sampleValid (sampleValid),
    .sampleVolt  (sampleVolt),
    .sampleCurr  (sampleCurr),
    .miso        (miso)
  );

endmodule

// File: tb/adc_spi_target_tb.sv
module adc_spi_target_tb;

  localparam int HALF  = 8;
  localparam int READY = 1000;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic sclk = 1'b0, csN = 1'b1, mosi = 1'b0;
  logic miso;
  logic sampleValid = 1'b0;
  logic [11:0] sampleVolt = '0, sampleCurr = '0;

  always #2 clk = ~clk;

  adc_spi_target #(.READY_CYCLES(READY)) u_dut (
    .clk(clk), .rstN(rstN), .sclk(sclk), .csN(csN), .mosi(mosi), .miso(miso),
    .sampleValid(sampleValid), .sampleVolt(sampleVolt), .sampleCurr(sampleCurr)
  );

  int checks = 0, errors = 0;
  bit done = 0;
  logic [7:0] expQ[$];
  string      tagQ[$];

  // Register model built from the requirements.
  logic [7:0]  mCfgA = 8'h99, mCfgB = 8'h00, mUpd = 8'h00, mCtrl = 8'h00;
  logic [11:0] mVolt = '0, mCurr = '0, mShVolt = '0, mShCurr = '0;
  bit          mReady = 0;

  function automatic logic [7:0] modelRead(logic [14:0] a);
    case (a)
      15'h0000: return mCfgA;
      15'h0001: return mCfgB;
      15'h0006: return 8'h02;
      15'h000C: return 8'h51;
      15'h000D: return 8'h04;
      15'h000F: return mUpd;
      15'h0100: return mCtrl;
      15'h0103: return {7'b0, mReady};
      15'h0200: return mVolt[7:0];
      15'h0201: return {4'h0, mVolt[11:8]};
      15'h0202: return mCurr[7:0];
      15'h0203: return {4'h0, mCurr[11:8]};
      default:  return 8'h00;
    endcase
  endfunction

  task automatic check(bit ok, string tag, logic [7:0] got, logic [7:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s got=%02h exp=%02h", tag, got, exp);
    end
  endtask

  task automatic halfWait();
    repeat (HALF) @(posedge clk);
    #1;
  endtask

  task automatic xferByte(logic [7:0] b);
    for (int i = 7; i >= 0; i--) begin
      mosi = b[i];
      halfWait();
      sclk = 1'b1;
      halfWait();
      sclk = 1'b0;
    end
  endtask

  task automatic startXfer(bit rd, logic [14:0] a);
    csN = 1'b0;
    halfWait();
    xferByte({rd, a[14:8]});
    xferByte(a[7:0]);
  endtask

  task automatic endXfer();
    halfWait();
    csN = 1'b1;
    repeat (3) halfWait();
  endtask

  // Driver: pushes expected bytes, then runs the read burst.
  task automatic readBurst(logic [14:0] a, int n, string tag);
    for (int k = 0; k < n; k++) begin
      expQ.push_back(modelRead(a - 15'(k)));
      tagQ.push_back(tag);
    end
    if (a >= 15'h0203 && (a - 15'(n - 1)) <= 15'h0200 && n >= 4) begin
      mVolt = mShVolt;
      mCurr = mShCurr;
    end
    startXfer(1'b1, a);
    for (int k = 0; k < n; k++) xferByte(8'h00);
    endXfer();
  endtask

  task automatic writeBurst(logic [14:0] a, logic [7:0] d0, logic [7:0] d1, int n);
    startXfer(1'b0, a);
    for (int k = 0; k < n; k++) begin
      logic [7:0] d;
      logic [14:0] w;
      d = (k == 0) ? d0 : d1;
      w = a - 15'(k);
      xferByte(d);
      case (w)
        15'h0000: mCfgA = d;
        15'h0001: mCfgB = d;
        15'h000F: mUpd  = d;
        15'h0100: mCtrl = d;
        default: ;
      endcase
    end
    endXfer();
  endtask

  task automatic setSample(logic [11:0] v, logic [11:0] c);
    @(posedge clk); #1;
    sampleVolt = v; sampleCurr = c; sampleValid = 1'b1;
    @(posedge clk); #1;
    sampleValid = 1'b0;
    mShVolt = v; mShCurr = c;
  endtask

  // Monitor: assembles MISO bytes of read transfers and compares with the queue.
  initial begin
    forever begin
      int   bitIdx;
      bit   rd;
      logic [7:0] rx;
      @(negedge csN);
      bitIdx = 0; rd = 0; rx = '0;
      forever begin
        @(posedge sclk or posedge csN);
        if (csN) break;
        if (bitIdx == 0) rd = mosi;
        if (bitIdx >= 16) rx = {rx[6:0], miso};
        bitIdx++;
        if (rd && bitIdx > 16 && ((bitIdx - 16) % 8) == 0) begin
          if (expQ.size() == 0) begin
            check(1'b0, "R1 unexpected byte", rx, 8'h00);
          end else begin
            logic [7:0] e;
            string t;
            e = expQ.pop_front();
            t = tagQ.pop_front();
            check(rx === e, t, rx, e);
          end
        end
      end
    end
  end

  task automatic finishRun();
    if (!done) begin
      done = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog expired");
    finishRun();
  end

  initial begin
    repeat (4) @(posedge clk); #1;
    rstN = 1'b1;
    #1;
    check(miso === 1'b0, "R1 idle miso", {7'b0, miso}, 8'h00);
    readBurst(15'h0103, 1, "R6 not ready");
    readBurst(15'h0000, 1, "R5 cfgA default");
    readBurst(15'h0001, 2, "R2 R5 descending defaults");
    readBurst(15'h000F, 1, "R5 update default");
    repeat (READY + 200) @(posedge clk); #1;
    mReady = 1;
    readBurst(15'h0103, 1, "R6 ready");
    readBurst(15'h000D, 2, "R3 identity");
    readBurst(15'h0006, 5, "R3 revision and zero span");
    readBurst(15'h0050, 1, "R3 unreadable");
    writeBurst(15'h0000, 8'h5A, 8'h00, 1);
    readBurst(15'h0000, 1, "R4 cfgA write");
    writeBurst(15'h0001, 8'h3C, 8'hC3, 2);
    readBurst(15'h0001, 2, "R2 write burst");
    writeBurst(15'h000F, 8'h77, 8'h00, 1);
    writeBurst(15'h0100, 8'hE1, 8'h00, 1);
    readBurst(15'h000F, 1, "R4 update write");
    readBurst(15'h0100, 1, "R4 ctrl write");
    writeBurst(15'h0006, 8'hFF, 8'h00, 1);
    writeBurst(15'h0103, 8'h00, 8'h00, 1);
    writeBurst(15'h0203, 8'hAA, 8'h55, 2);
    readBurst(15'h0006, 1, "R4 revision kept");
    readBurst(15'h0103, 1, "R4 status kept");
    readBurst(15'h0203, 2, "R4 data kept");
    check(miso === 1'b0, "R1 idle miso after reads", {7'b0, miso}, 8'h00);
    setSample(12'hABC, 12'h123);
    readBurst(15'h0200, 1, "R8 capture hidden");
    readBurst(15'h0203, 4, "R9 pre-commit values");
    readBurst(15'h0203, 4, "R7 committed layout");
    setSample(12'h456, 12'hFED);
    readBurst(15'h0203, 3, "R10 short burst");
    readBurst(15'h0203, 1, "R10 split 0203");
    readBurst(15'h0202, 1, "R10 split 0202");
    readBurst(15'h0201, 1, "R10 split 0201");
    readBurst(15'h0200, 1, "R10 split 0200");
    readBurst(15'h0202, 3, "R10 low start");
    readBurst(15'h0203, 4, "R10 pending kept");
    readBurst(15'h0203, 4, "R9 R7 second commit");
    setSample(12'h0F1, 12'h80E);
    readBurst(15'h0205, 6, "R9 burst from above");
    readBurst(15'h0203, 4, "R7 third commit");
    wait (expQ.size() == 0);
    finishRun();
  end

endmodule